// File: doc/BRIEF.md
# Segment Base Translator

This block turns a program address, given as a segment register number and a 32-bit offset, into a flat 32-bit linear address. It holds six segment registers. Each one has a hidden cache that stores the segment base and a null marker. Software loads a register by giving it a 16-bit selector. The block then builds the descriptor address from the selector and one of two table base inputs, and reads the 8-byte descriptor as two 32-bit words through a simple memory read port. It keeps only the assembled base.

A translation reads the cached base and adds the offset. It never touches memory. A load stalls translations until both descriptor words have arrived. A selector that names entry zero of the global table is treated as null: it loads a zero base with no memory access, and every later translation through that register reports a fault. The block checks no limits, types or privileges.

Top module: `seg_xlate`

## Requirements
- R1: A selector carries the descriptor index in bits 15..3 and the table choice in bit 2. Bit 2 = 0 picks `gtab_base` and bit 2 = 1 picks `ltab_base`. The low descriptor word is read at table base + index*8.
- R2: Selector bits 1..0 change neither the descriptor address nor the cached base.
- R3: A non-null load reads the low word first and then the high word at the low address + 4. `mem_req` stays high and `mem_addr` stays unchanged until `mem_rvalid` returns each word.
- R4: The cached base is {high[31:24], high[7:0], low[31:16]}, where low and high are the two descriptor words.
- R5: `busy` is high from the cycle after a non-null load is accepted until the high word returns. While `busy` is high, `xl_ready` is low, translate requests wait, and any load request is ignored.
- R6: A translate request accepted at a clock edge produces `lin_valid` for one cycle after that edge, with `lin_addr` = cached base + offset modulo 2^32.
- R7: Translations issue no memory reads. `mem_req` is high only while a load is fetching.
- R8: A selector with bits 15..2 all zero is null. It loads base 0 in the accept cycle with no fetch and no `busy`. Translations through that register assert `lin_fault`, with `lin_addr` = offset.
- R9: After reset all six registers are null, and `busy` and `lin_valid` are low.
- R10: The six registers are independent. A segment number of 6 or 7 makes a translation fault, and a load that names such a segment number is ignored.
- R11: Changing a table base after a load does not change a cached base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Segment register load request |
| ld_seg | input | 3 | Segment register to load |
| ld_sel | input | 16 | Selector to load |
| busy | output | 1 | Descriptor fetch in progress |
| gtab_base | input | 32 | Global descriptor table base |
| ltab_base | input | 32 | Local descriptor table base |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data word |
| xl_valid | input | 1 | Translate request |
| xl_seg | input | 3 | Segment register used for translation |
| xl_off | input | 32 | Offset to translate |
| xl_ready | output | 1 | Translate request can be accepted |
| lin_valid | output | 1 | Linear address result valid |
| lin_addr | output | 32 | Linear address |
| lin_fault | output | 1 | Translation used a null or invalid segment |

## Verification
The bound checker watches several rules on every cycle. It confirms that memory reads happen only while `busy` is high, that a waiting read keeps its address, and that `xl_ready` is low while a fetch runs. It also confirms that each result follows an accepted request by one cycle, that faulted results carry the raw offset, and that a null load never raises `busy`. Only the bench scenarios can show the values involved: the descriptor addresses for each table, the way the base is assembled from scattered fields, that the privilege bits and later table base changes have no effect, that loads issued during a fetch are dropped, and that stalled translations finish with the newly loaded base.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int NSEG = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_valid,
  input  logic [2:0]  ld_seg,
  input  logic [15:0] ld_sel,
  output logic        busy,
  input  logic [31:0] gtab_base,
  input  logic [31:0] ltab_base,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  input  logic        xl_valid,
  input  logic [2:0]  xl_seg,
  input  logic [31:0] xl_off,
  output logic        xl_ready,
  output logic        lin_valid,
  output logic [31:0] lin_addr,
  output logic        lin_fault
);
  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_t;

  st_t         state;
  logic [31:0] desc_q;
  logic [15:0] lo_q;
  logic [2:0]  tgt_q;
  logic [31:0] base_q [NSEG];
  logic [NSEG-1:0] null_q;

  logic        seg_ok, xseg_ok, accept_ld, sel_null;
  logic [31:0] desc_addr, cur_base;
  logic        cur_fault;
  logic        unused_bits;

  assign seg_ok    = int'(ld_seg) < NSEG;
  assign xseg_ok   = int'(xl_seg) < NSEG;
  assign accept_ld = ld_valid && state == S_IDLE && seg_ok;
  assign sel_null  = ld_sel[15:2] == 14'd0;
  assign desc_addr = (ld_sel[2] ? ltab_base : gtab_base) + {16'd0, ld_sel[15:3], 3'b000};

  assign busy     = state != S_IDLE;
  assign xl_ready = !busy;
  assign mem_req  = busy;
  assign mem_addr = (state == S_HI) ? desc_q + 32'd4 : desc_q;

  assign cur_base  = (xseg_ok && !null_q[xl_seg]) ? base_q[xl_seg] : 32'd0;
  assign cur_fault = !xseg_ok || null_q[xl_seg];

  assign unused_bits = ^{ld_sel[1:0], mem_rdata[15:8]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      desc_q    <= '0;
      lo_q      <= '0;
      tgt_q     <= '0;
      null_q    <= '1;
      lin_valid <= 1'b0;
      lin_addr  <= '0;
      lin_fault <= 1'b0;
      for (int i = 0; i < NSEG; i++) base_q[i] <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept_ld) begin
          if (sel_null) begin
            base_q[ld_seg] <= '0;
            null_q[ld_seg] <= 1'b1;
          end else begin
            desc_q <= desc_addr;
            tgt_q  <= ld_seg;
            state  <= S_LO;
          end
        end
        S_LO: if (mem_rvalid) begin
          lo_q  <= mem_rdata[31:16];
          state <= S_HI;
        end
        S_HI: if (mem_rvalid) begin
          base_q[tgt_q] <= {mem_rdata[31:24], mem_rdata[7:0], lo_q};
          null_q[tgt_q] <= 1'b0;
          state         <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      lin_valid <= xl_valid && xl_ready;
      if (xl_valid && xl_ready) begin
        lin_addr  <= cur_base + xl_off;
        lin_fault <= cur_fault;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int NSEG = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ld_valid,
  input logic [2:0]  ld_seg,
  input logic [15:0] ld_sel,
  input logic        busy,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        xl_valid,
  input logic [31:0] xl_off,
  input logic        xl_ready,
  input logic        lin_valid,
  input logic [31:0] lin_addr,
  input logic        lin_fault
);
  // R7: reads only during a fetch
  p_read_in_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !xl_ready);

  p_result_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lin_valid |-> $past(xl_valid && xl_ready));

  p_fault_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lin_valid && lin_fault) |-> lin_addr == $past(xl_off));

  p_null_nofetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !busy && int'(ld_seg) < NSEG && ld_sel[15:2] == 14'd0) |=> !busy);
endmodule

bind seg_xlate seg_xlate_chk #(.NSEG(NSEG)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel),
  .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
  .xl_valid(xl_valid), .xl_off(xl_off), .xl_ready(xl_ready),
  .lin_valid(lin_valid), .lin_addr(lin_addr), .lin_fault(lin_fault)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  logic        clk = 0, rst_n = 0;
  logic        ld_valid = 0;
  logic [2:0]  ld_seg = 0;
  logic [15:0] ld_sel = 0;
  logic        busy;
  logic [31:0] gtab_base = 0, ltab_base = 0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;
  logic        xl_valid = 0;
  logic [2:0]  xl_seg = 0;
  logic [31:0] xl_off = 0;
  logic        xl_ready, lin_valid, lin_fault;
  logic [31:0] lin_addr;

  seg_xlate u_dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int lat = 0, wcnt = 0;
  logic [31:0] addr_log [$];
  logic [31:0] q_addr [$];
  logic        q_fault [$];
  string       q_req [$];
  logic [31:0] m_base [6];
  logic        m_null [6];
  logic [31:0] m_desc;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mfn(input logic [31:0] a);
    return (a ^ 32'hA5C3_1F07) * 32'h0001_0193 + 32'h1234_5678;
  endfunction

  // memory responder
  always @(negedge clk) begin
    mem_rvalid <= 0;
    if (rst_n && mem_req) begin
      if (wcnt >= lat) begin
        mem_rvalid <= 1;
        mem_rdata  <= mfn(mem_addr);
        addr_log.push_back(mem_addr);
        wcnt = 0;
      end else wcnt++;
    end else wcnt = 0;
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && lin_valid) begin
      if (q_addr.size() == 0) chk(0, "R6 unexpected result", lin_addr, 0);
      else begin
        logic [31:0] ea; logic ef; string r;
        ea = q_addr.pop_front(); ef = q_fault.pop_front(); r = q_req.pop_front();
        chk(lin_addr == ea, r, lin_addr, ea);
        chk(lin_fault == ef, r, {31'd0, lin_fault}, {31'd0, ef});
      end
    end
  end

  task automatic xl(input int seg, input logic [31:0] off, input string req, output int stalls);
    @(negedge clk);
    xl_valid = 1; xl_seg = seg[2:0]; xl_off = off; stalls = 0;
    while (!xl_ready) begin @(negedge clk); stalls++; end
    if (seg < 6 && !m_null[seg]) begin
      q_addr.push_back(m_base[seg] + off); q_fault.push_back(0);
    end else begin
      q_addr.push_back(off); q_fault.push_back(1);
    end
    q_req.push_back(req);
    @(negedge clk);
    xl_valid = 0;
  endtask

  task automatic start_load(input int seg, input logic [15:0] sel);
    @(negedge clk);
    while (busy) @(negedge clk);
    ld_valid = 1; ld_seg = seg[2:0]; ld_sel = sel;
    if (seg < 6) begin
      if (sel[15:2] == 0) begin
        m_base[seg] = 0; m_null[seg] = 1;
      end else begin
        logic [31:0] lo, hi;
        m_desc = (sel[2] ? ltab_base : gtab_base) + {16'd0, sel[15:3], 3'b000};
        lo = mfn(m_desc); hi = mfn(m_desc + 4);
        m_base[seg] = {hi[31:24], hi[7:0], lo[31:16]};
        m_null[seg] = 0;
      end
    end
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic load(input int seg, input logic [15:0] sel, input string req);
    bit isnull;
    isnull = (sel[15:2] == 0);
    start_load(seg, sel);
    if (!isnull) chk(busy == 1, "R5 busy after load", {31'd0, busy}, 1);
    else chk(busy == 0, "R8 null load no busy", {31'd0, busy}, 0);
    while (busy) @(negedge clk);
    if (!isnull) begin
      chk(addr_log.size() == 2, {req, " two reads"}, addr_log.size(), 2);
      if (addr_log.size() == 2) begin
        logic [31:0] a0, a1;
        a0 = addr_log.pop_front(); a1 = addr_log.pop_front();
        chk(a0 == m_desc, {req, " low word address"}, a0, m_desc);
        chk(a1 == m_desc + 4, "R3 high word address", a1, m_desc + 4);
      end
      addr_log.delete();
    end else begin
      chk(addr_log.size() == 0, "R8 null load no reads", addr_log.size(), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int st;
    for (int i = 0; i < 6; i++) begin m_base[i] = 0; m_null[i] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9
    chk(busy == 0, "R9 busy after reset", {31'd0, busy}, 0);
    chk(lin_valid == 0, "R9 lin_valid after reset", {31'd0, lin_valid}, 0);
    chk(xl_ready == 1, "R9 ready after reset", {31'd0, xl_ready}, 1);
    for (int i = 0; i < 6; i++) xl(i, 32'h1000 + i, "R9 reset null fault", st);

    gtab_base = 32'h0001_0000; ltab_base = 32'h0080_0000;
    lat = 0;
    load(1, {13'd5, 1'b0, 2'b00}, "R1 global table");
    xl(1, 32'h100, "R4 R6 translate seg1", st);
    lat = 2;
    load(2, {13'd3, 1'b1, 2'b11}, "R1 local table");
    xl(2, 32'h2222_0000, "R4 translate seg2", st);
    load(3, {13'd3, 1'b1, 2'b00}, "R2 rpl ignored");
    chk(m_base[3] == m_base[2], "R2 same base model", m_base[3], m_base[2]);
    xl(3, 32'h2222_0000, "R2 translate seg3 equals seg2", st);
    xl(1, 32'hFFFF_FFF0, "R6 wrap", st);

    // R7: translations issue no reads
    for (int i = 0; i < 4; i++) begin
      xl(1 + (i % 3), 32'h40 * i, "R7 burst", st);
      chk(mem_req == 0, "R7 no mem_req during translate", {31'd0, mem_req}, 0);
    end
    chk(addr_log.size() == 0, "R7 no reads from translate", addr_log.size(), 0);

    // R11
    gtab_base = 32'h7777_0000; ltab_base = 32'h0;
    xl(1, 32'h8, "R11 cached base kept", st);
    xl(2, 32'h8, "R11 cached base kept ldt", st);
    gtab_base = 32'h0001_0000; ltab_base = 32'h0080_0000;

    // R5 stall and ignored load
    lat = 3;
    start_load(4, {13'd9, 1'b0, 2'b01});
    fork
      begin
        xl(4, 32'h55, "R5 stalled translate uses new base", st);
        chk(st >= 2, "R5 translate stalled", st, 2);
      end
      begin
        @(negedge clk);
        chk(busy == 1 && xl_ready == 0, "R5 ready low while busy", {31'd0, xl_ready}, 0);
        ld_valid = 1; ld_seg = 3'd4; ld_sel = {13'd20, 1'b1, 2'b00};
        @(negedge clk);
        ld_valid = 0;
      end
    join
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(busy == 0, "R5 ignored load started nothing", {31'd0, busy}, 0);
    chk(addr_log.size() == 2, "R5 only one fetch", addr_log.size(), 2);
    addr_log.delete();
    xl(4, 32'h99, "R5 base from first load", st);

    // R8
    lat = 1;
    load(1, 16'h0003, "R8 null");
    xl(1, 32'hABCD_0123, "R8 null fault", st);
    load(5, 16'h0004, "R1 ldt index zero not null");
    xl(5, 32'h10, "R8 ldt index zero no fault", st);

    // R10
    xl(6, 32'h600, "R10 seg6 fault", st);
    xl(7, 32'h700, "R10 seg7 fault", st);
    @(negedge clk);
    ld_valid = 1; ld_seg = 3'd7; ld_sel = {13'd4, 1'b0, 2'b00};
    @(negedge clk);
    ld_valid = 0;
    chk(busy == 0, "R10 load seg7 ignored", {31'd0, busy}, 0);
    chk(addr_log.size() == 0, "R10 load seg7 no reads", addr_log.size(), 0);
    load(0, {13'd77, 1'b0, 2'b10}, "R10 load seg0");
    for (int i = 0; i < 6; i++) xl(i, 32'h3000 + i, "R10 independent registers", st);

    repeat (4) @(negedge clk);
    chk(q_addr.size() == 0, "R6 all results seen", q_addr.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule